// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for every beat of one SDRAM read or write burst. The settings come from a mode word that is latched when the mode-write strobe is accepted. These settings are the burst length, the beat ordering, the CAS latency and a flag that makes writes single-beat. A read or write command carries a starting column and an auto-precharge flag. From the next cycle on, the block presents one column per clock with a valid strobe. It also marks the cycles in which data is on the bus and pulses an end flag on the last beat of a burst that runs to its full length.

A burst can be cut short in three ways: a burst stop command, a precharge of the bank, or a new read or write command, which starts its own burst at once. A burst issued with auto-precharge refuses the last two kinds of interruption and reports each refused request on an error flag. A full-page burst walks the whole page and wraps back to the start of the page until it is stopped. The data-valid window follows the latched CAS latency, so read data after a stop drains for the correct number of cycles.

Top module: `sdram_burst_seq`

## Requirements
- R1: A mode write takes effect only in a cycle in which `colValid` is low, neither `cmdRd` nor `cmdWr` is high, and mode bits 8..7 are both zero. Any other mode write is ignored, and the previous settings keep governing later bursts.
- R2: After reset `colValid`, `dataValid`, `burstEnd` and `cmdError` are low. A read or write command that is not refused raises `colValid` in the next cycle, with `colAddr` equal to the command's column and `colWrite` high for a write.
- R3: Mode bits 2..0 set the burst length: 000 is 1 beat, 001 is 2, 010 is 4, 011 is 8 and 111 is full page. The reserved codes 100, 101 and 110 give 1 beat. With no other command, `colValid` stays high for exactly that many consecutive cycles.
- R4: With mode bit 3 = 0 (sequential), beat k keeps the column bits above log2(BL) from the start column. The low log2(BL) bits are (start + k) mod BL.
- R5: With mode bit 3 = 1 and a length of 4 or 8 (interleaved), the low log2(BL) bits of beat k are start XOR k. At lengths 1 and 2, and at full page, the order is sequential.
- R6: A full-page burst adds 1 modulo 512 to the column on every beat. It continues until it is terminated and never raises `burstEnd`.
- R7: With mode bit 9 = 1, every write burst is one beat long, while reads keep the programmed length.
- R8: `burstEnd` is high only together with the final column of a burst that reaches its programmed length. It is not raised for a stopped or interrupted burst.
- R9: `cmdStop` in a cycle with `colValid` high makes that cycle's column the last one, so `colValid` is low in the next cycle.
- R10: `dataValid` is high in every cycle that carries a write column. For each read column it is high exactly CL-1 cycles later, where CL = 2 when mode bits 6..4 are 010 and CL = 3 otherwise. After a read is stopped, data therefore stays valid for 1 cycle at CL 2 and for 2 cycles at CL 3.
- R11: A read or write command during a burst without auto-precharge ends that burst. The next cycle carries the new command's column as beat 0, and commands may arrive every cycle.
- R12: A precharge (`cmdPrecharge`) during a beat other than the final one of a burst without auto-precharge ends the burst after the current beat. A precharge while idle has no effect.
- R13: During a beat other than the final one of a burst with auto-precharge, read, write and precharge requests are ignored and the burst continues unchanged. Each such request raises `cmdError` for one cycle in the following cycle. `cmdError` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWrEn | input | 1 | Mode register write strobe |
| modeWord | input | 10 | Mode word: bit 9 single-beat writes, 8..7 must be zero, 6..4 latency code, 3 ordering, 2..0 length code |
| cmdRd | input | 1 | Read command |
| cmdWr | input | 1 | Write command |
| cmdCol | input | 9 | Starting column of the command |
| cmdAutoPre | input | 1 | Auto-precharge flag of the command |
| cmdStop | input | 1 | Burst stop command |
| cmdPrecharge | input | 1 | Precharge of the bank |
| colAddr | output | 9 | Column address of the current beat |
| colValid | output | 1 | A beat is issued this cycle |
| colWrite | output | 1 | The current burst is a write |
| dataValid | output | 1 | Data is on the bus this cycle |
| burstEnd | output | 1 | Final beat of a burst that reached its full length |
| cmdError | output | 1 | A request was refused in the previous cycle |

## Verification
The hardest case to reach from the ports is a refused request. It needs a burst with auto-precharge still in a middle beat, and it must be told apart from the final beat, where a new command is legal again. The stimulus starts an 8-beat auto-precharge read and fires a read, a precharge and a write on consecutive middle beats. It then counts to the final beat and issues a read that must be accepted. A second awkward case is the read-data drain after a stop at both latencies, including a wrapping full-page burst that is stopped.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  localparam int MODE_W = 10;

  // Fields of the mode word that the sequencer uses.
  typedef struct packed {
    logic       wrSingle;  // writes are single beat
    logic [2:0] casCode;   // latency code, 010 means two cycles
    logic       ilv;       // interleaved ordering request
    logic [2:0] lenCode;   // burst length code
  } modeCfg_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic modeLoad;
    logic load;
    logic loadWrite;
    logic advance;
  } seqStrobe_t;

endpackage

// File: rtl/sbs_datapath.sv
module sbs_datapath
  import sbs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  modeCfg_t         modeIn,
  input  logic [COL_W-1:0] startIn,
  output logic [COL_W-1:0] colAddr,
  output logic             lastBeat,
  output logic             casLat3
);

  localparam logic [COL_W-1:0] MASK_2 = COL_W'(1);
  localparam logic [COL_W-1:0] MASK_4 = COL_W'(3);
  localparam logic [COL_W-1:0] MASK_8 = COL_W'(7);

  modeCfg_t         modeQ;
  logic [COL_W-1:0] startQ;
  logic [COL_W-1:0] beatQ;
  logic [COL_W-1:0] maskQ;
  logic             fullQ;
  logic             ilvQ;

  logic [COL_W-1:0] nextMask;
  logic             nextFull;
  logic             nextIlv;
  logic             singleWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
    end else if (strb.modeLoad) begin
      modeQ <= modeIn;
    end
  end

  assign casLat3  = (modeQ.casCode != 3'b010);
  assign singleWr = strb.loadWrite && modeQ.wrSingle;

  // Length decode for the burst being loaded.
  always_comb begin
    nextFull = 1'b0;
    unique case (modeQ.lenCode)
      3'b001:  nextMask = MASK_2;
      3'b010:  nextMask = MASK_4;
      3'b011:  nextMask = MASK_8;
      3'b111: begin
        nextMask = '1;
        nextFull = 1'b1;
      end
      default: nextMask = '0;
    endcase
    if (singleWr) begin
      nextMask = '0;
      nextFull = 1'b0;
    end
    nextIlv = modeQ.ilv && !singleWr &&
              ((modeQ.lenCode == 3'b010) || (modeQ.lenCode == 3'b011));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      beatQ  <= '0;
      maskQ  <= '0;
      fullQ  <= 1'b0;
      ilvQ   <= 1'b0;
    end else if (strb.load) begin
      startQ <= startIn;
      beatQ  <= '0;
      maskQ  <= nextMask;
      fullQ  <= nextFull;
      ilvQ   <= nextIlv;
    end else if (strb.advance) begin
      beatQ <= beatQ + COL_W'(1);
    end
  end

  logic [COL_W-1:0] seqLow;
  logic [COL_W-1:0] ilvLow;
  logic [COL_W-1:0] pickLow;

  assign seqLow  = startQ + beatQ;
  assign ilvLow  = startQ ^ beatQ;
  assign pickLow = ilvQ ? ilvLow : seqLow;

  // Bits inside the burst block follow the count, bits above stay fixed.
  for (genvar b = 0; b < COL_W; b++) begin : g_colBit
    assign colAddr[b] = maskQ[b] ? pickLow[b] : startQ[b];
  end

  assign lastBeat = !fullQ && (beatQ == maskQ);

endmodule

// File: rtl/sbs_control.sv
module sbs_control
  import sbs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWrEn,
  input  logic       modeTestBits,
  input  logic       cmdRd,
  input  logic       cmdWr,
  input  logic       cmdAutoPre,
  input  logic       cmdStop,
  input  logic       cmdPrecharge,
  input  logic       lastBeat,
  input  logic       casLat3,
  output seqStrobe_t strb,
  output logic       colValid,
  output logic       colWrite,
  output logic       dataValid,
  output logic       burstEnd,
  output logic       cmdError
);

  logic       autoPreQ;
  logic [1:0] rdPipe;
  logic       anyCmd;
  logic       guarded;
  logic       accept;
  logic       finish;
  logic       readBeat;

  assign anyCmd   = cmdRd || cmdWr;
  assign guarded  = colValid && autoPreQ && !lastBeat;
  assign accept   = anyCmd && !guarded;
  assign finish   = colValid && (lastBeat || cmdStop || (cmdPrecharge && !guarded));
  assign readBeat = colValid && !colWrite;

  always_comb begin
    strb.modeLoad  = modeWrEn && !modeTestBits && !colValid && !anyCmd;
    strb.load      = accept;
    strb.loadWrite = cmdWr;
    strb.advance   = colValid && !accept && !finish;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colValid <= 1'b0;
      colWrite <= 1'b0;
      autoPreQ <= 1'b0;
      cmdError <= 1'b0;
      rdPipe   <= '0;
    end else begin
      if (accept) begin
        colValid <= 1'b1;
        colWrite <= cmdWr;
        autoPreQ <= cmdAutoPre;
      end else if (finish) begin
        colValid <= 1'b0;
      end
      cmdError  <= (anyCmd || cmdPrecharge) && guarded;
      rdPipe[1] <= readBeat && casLat3;
      rdPipe[0] <= rdPipe[1] || (readBeat && !casLat3);
    end
  end

  assign dataValid = (colValid && colWrite) || rdPipe[0];
  assign burstEnd  = colValid && lastBeat;

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWrEn,
  input  logic [MODE_W-1:0] modeWord,
  input  logic              cmdRd,
  input  logic              cmdWr,
  input  logic [COL_W-1:0]  cmdCol,
  input  logic              cmdAutoPre,
  input  logic              cmdStop,
  input  logic              cmdPrecharge,
  output logic [COL_W-1:0]  colAddr,
  output logic              colValid,
  output logic              colWrite,
  output logic              dataValid,
  output logic              burstEnd,
  output logic              cmdError
);

  seqStrobe_t strb;
  modeCfg_t   modeIn;
  logic       lastBeat;
  logic       casLat3;
  logic       modeTestBits;

  assign modeIn = '{wrSingle: modeWord[9], casCode: modeWord[6:4],
                    ilv: modeWord[3], lenCode: modeWord[2:0]};
  assign modeTestBits = |modeWord[8:7];

  sbs_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .modeWrEn     (modeWrEn),
    .modeTestBits (modeTestBits),
    .cmdRd        (cmdRd),
    .cmdWr        (cmdWr),
    .cmdAutoPre   (cmdAutoPre),
    .cmdStop      (cmdStop),
    .cmdPrecharge (cmdPrecharge),
    .lastBeat     (lastBeat),
    .casLat3      (casLat3),
    .strb         (strb),
    .colValid     (colValid),
    .colWrite     (colWrite),
    .dataValid    (dataValid),
    .burstEnd     (burstEnd),
    .cmdError     (cmdError)
  );

  sbs_datapath #(.COL_W(COL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .modeIn   (modeIn),
    .startIn  (cmdCol),
    .colAddr  (colAddr),
    .lastBeat (lastBeat),
    .casLat3  (casLat3)
  );

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdRd,
  input logic             cmdWr,
  input logic [COL_W-1:0] cmdCol,
  input logic             cmdStop,
  input logic [COL_W-1:0] colAddr,
  input logic             colValid,
  input logic             colWrite,
  input logic             dataValid,
  input logic             burstEnd,
  input logic             cmdError
);

  a_r2_first_col: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRd || cmdWr) && !colValid |=>
      colValid && (colAddr == $past(cmdCol)) && (colWrite == $past(cmdWr)));

  a_r9_stop_ends: assert property (@(posedge clk) disable iff (!rstN)
    colValid && cmdStop && !cmdRd && !cmdWr |=> !colValid);

  a_r8_end_has_col: assert property (@(posedge clk) disable iff (!rstN)
    burstEnd |-> colValid);

  a_r8_idle_after_end: assert property (@(posedge clk) disable iff (!rstN)
    burstEnd && !cmdRd && !cmdWr |=> !colValid);

  a_r13_refused_continues: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> colValid);

  a_r10_write_data: assert property (@(posedge clk) disable iff (!rstN)
    colValid && colWrite |-> dataValid);

  a_r10_data_source: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> (colValid && colWrite) || $past(colValid && !colWrite) ||
                  $past(colValid && !colWrite, 2));

endmodule

bind sdram_burst_seq sbs_checker #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdRd     (cmdRd),
  .cmdWr     (cmdWr),
  .cmdCol    (cmdCol),
  .cmdStop   (cmdStop),
  .colAddr   (colAddr),
  .colValid  (colValid),
  .colWrite  (colWrite),
  .dataValid (dataValid),
  .burstEnd  (burstEnd),
  .cmdError  (cmdError)
);

// File: tb/tb_sdram_burst_seq.sv
`timescale 1ns/1ps
module tb_sdram_burst_seq;

  localparam int COL_W = 9;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             modeWrEn = 1'b0;
  logic [9:0]       modeWord = '0;
  logic             cmdRd = 1'b0, cmdWr = 1'b0, cmdAutoPre = 1'b0;
  logic             cmdStop = 1'b0, cmdPrecharge = 1'b0;
  logic [COL_W-1:0] cmdCol = '0;
  logic [COL_W-1:0] colAddr;
  logic             colValid, colWrite, dataValid, burstEnd, cmdError;

  always #2.5 clk = ~clk;

  sdram_burst_seq #(.COL_W(COL_W)) dut (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWord(modeWord),
    .cmdRd(cmdRd), .cmdWr(cmdWr), .cmdCol(cmdCol), .cmdAutoPre(cmdAutoPre),
    .cmdStop(cmdStop), .cmdPrecharge(cmdPrecharge), .colAddr(colAddr),
    .colValid(colValid), .colWrite(colWrite), .dataValid(dataValid),
    .burstEnd(burstEnd), .cmdError(cmdError)
  );

  int    checks = 0;
  int    errors = 0;
  int    wdog = 0;
  bit    done = 0;
  string curReq = "R2";

  // Reference model state
  bit mSingle, mIlv;
  int mCas, mLen;
  bit busy, isWr, ap, expErr;
  int start, beat, bl, il, cyc;
  bit due[4];

  function automatic int lenOf(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int expAddr();
    int base, off;
    if (bl == 0) return (start + beat) % PAGE;
    base = start - (start % bl);
    off  = il ? ((start % bl) ^ beat) : (((start % bl) + beat) % bl);
    return base + off;
  endfunction

  always @(posedge clk) begin
    int  cl;
    bit  last, prot, anyc, acc;
    if (!rstN) begin
      mSingle = 0; mIlv = 0; mCas = 0; mLen = 0;
      busy = 0; isWr = 0; ap = 0; expErr = 0;
      start = 0; beat = 0; bl = 1; il = 0; cyc = 0;
      for (int i = 0; i < 4; i++) due[i] = 0;
    end else begin
      cl   = (mCas == 2) ? 2 : 3;
      last = busy && bl != 0 && beat == bl - 1;
      prot = busy && ap && !last;
      anyc = cmdRd || cmdWr;
      if (busy && !isWr) due[(cyc + cl - 1) % 4] = 1;
      due[cyc % 4] = 0;
      cyc++;
      expErr = (anyc || cmdPrecharge) && prot;
      if (modeWrEn && !busy && !anyc && modeWord[8:7] == 2'b00) begin
        mSingle = modeWord[9];
        mCas    = int'(modeWord[6:4]);
        mIlv    = modeWord[3];
        mLen    = int'(modeWord[2:0]);
      end
      acc = anyc && !prot;
      if (acc) begin
        busy  = 1;
        start = int'(cmdCol);
        beat  = 0;
        isWr  = cmdWr;
        ap    = cmdAutoPre;
        bl    = (cmdWr && mSingle) ? 1 : lenOf(mLen);
        il    = (mIlv && (bl == 4 || bl == 8)) ? 1 : 0;
      end else if (busy) begin
        if (last || cmdStop || (cmdPrecharge && !prot)) busy = 0;
        else beat++;
      end
    end
  end

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rstN) begin
        chk(int'(colValid), 0, "reset colValid");
        chk(int'(dataValid), 0, "reset dataValid");
        chk(int'(cmdError), 0, "reset cmdError");
      end else begin
        chk(int'(colValid), int'(busy), "colValid");
        if (busy) begin
          chk(int'(colAddr), expAddr(), "colAddr");
          chk(int'(colWrite), int'(isWr), "colWrite");
        end
        chk(int'(burstEnd), int'(busy && bl != 0 && beat == bl - 1), "burstEnd");
        chk(int'(dataValid), int'((busy && isWr) || due[cyc % 4]), "dataValid");
        chk(int'(cmdError), int'(expErr), "cmdError");
      end
    end
  end

  always @(posedge clk) begin
    wdog++;
    if (wdog > 20000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", wdog);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setMode(input int len, input int ilv, input int cas,
                         input int single, input int tst = 0);
    modeWord = {1'(single), 2'(tst), 3'(cas), 1'(ilv), 3'(len)};
    modeWrEn = 1'b1;
    @(negedge clk);
    modeWrEn = 1'b0;
  endtask

  task automatic cmd(input bit rd, input bit wr, input int col, input bit apre = 0);
    cmdRd = rd; cmdWr = wr; cmdCol = COL_W'(col); cmdAutoPre = apre;
    @(negedge clk);
    cmdRd = 0; cmdWr = 0; cmdAutoPre = 0;
  endtask

  task automatic stopCmd();
    cmdStop = 1'b1;
    @(negedge clk);
    cmdStop = 1'b0;
  endtask

  task automatic preCmd();
    cmdPrecharge = 1'b1;
    @(negedge clk);
    cmdPrecharge = 1'b0;
  endtask

  initial begin
    curReq = "R2";
    idle(4);
    rstN = 1'b1;
    idle(2);

    curReq = "R3 R8";
    setMode(0, 0, 2, 0); cmd(1, 0, 5);   idle(3);
    setMode(1, 0, 2, 0); cmd(1, 0, 13);  idle(4);
    setMode(2, 0, 2, 0); cmd(1, 0, 13);  idle(6);
    setMode(3, 0, 2, 0); cmd(1, 0, 501); idle(10);
    for (int c = 4; c < 7; c++) begin
      setMode(c, 0, 2, 0); cmd(1, 0, 77); idle(3);
    end

    curReq = "R4";
    setMode(2, 0, 3, 0); cmd(1, 0, 203); idle(6);
    setMode(3, 0, 3, 0); cmd(1, 0, 46);  idle(10);

    curReq = "R5";
    setMode(2, 1, 2, 0); cmd(1, 0, 6);  idle(6);
    setMode(3, 1, 2, 0); cmd(1, 0, 11); idle(10);
    setMode(1, 1, 2, 0); cmd(1, 0, 3);  idle(3);
    setMode(0, 1, 2, 0); cmd(1, 0, 9);  idle(3);
    setMode(7, 1, 2, 0); cmd(1, 0, 14); idle(5); stopCmd(); idle(4);

    curReq = "R6";
    setMode(7, 0, 3, 0); cmd(1, 0, 508); idle(8);
    curReq = "R9 R10";
    stopCmd(); idle(5);

    curReq = "R10";
    setMode(3, 0, 2, 0); cmd(1, 0, 20); idle(3); stopCmd(); idle(4);
    cmd(0, 1, 30); idle(10);

    curReq = "R7";
    setMode(2, 0, 2, 1); cmd(0, 1, 10); idle(3);
    cmd(1, 0, 10); idle(6);

    curReq = "R1";
    setMode(3, 0, 2, 0); cmd(1, 0, 0); idle(2);
    setMode(0, 0, 2, 0); idle(8);
    cmd(1, 0, 40); idle(10);
    setMode(0, 0, 2, 0, 1); cmd(1, 0, 40); idle(10);

    curReq = "R11";
    setMode(3, 0, 2, 0); cmd(1, 0, 0); idle(2);
    cmd(0, 1, 100); idle(3);
    cmd(1, 0, 200); cmd(1, 0, 201); cmd(0, 1, 202); cmd(1, 0, 300); idle(10);

    curReq = "R12";
    cmd(1, 0, 40); idle(1); preCmd(); idle(5);
    preCmd(); idle(2);

    curReq = "R13";
    cmd(1, 0, 16, 1); idle(1);
    cmd(1, 0, 200); preCmd(); cmd(0, 1, 5);
    idle(3);
    cmd(1, 0, 300); idle(10);
    setMode(7, 0, 3, 0); cmd(1, 0, 250, 1); idle(2);
    cmd(0, 1, 9); idle(2); stopCmd(); idle(5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule